// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block produces the instruction fetch address for a simple in-order core whose control transfers may carry architectural delay slots. Each cycle the core presents the decoded control-flow request of the instruction at the current fetch address: none, jump, call or return. The request is flagged as delayed or immediate, and it comes with a target and an interrupt request line. The block decides the next fetch address. A delayed transfer lets a fixed number of sequential slot instructions issue before the new target takes effect. An immediate transfer redirects at once.

Calls push a return point onto an internal stack. A delayed call pushes the point past its slots, so a return never re-executes the caller's slot instructions. Interrupts are held while slot instructions are still to come, and are then taken to a fixed vector. The block records the address that would otherwise have been fetched next. A control-flow request that arrives inside a slot window is not acted on and raises a sticky error.

Top module: `dslot_pc_seq`

## Requirements
- R1: While reset is high and in the cycle it releases, fetch_valid is 0, fetch_addr is 0, and slot_err and ras_err are 0. The first valid fetch is from address 0.
- R2: Suppose a valid cycle is not a slot, carries no request (cf_op 0) and takes no interrupt. The next fetch_addr is then the current one plus 1.
- R3: A jump (cf_op 1) with cf_delayed 1 is followed by SLOTS sequential fetches and then by cf_target.
- R4: A jump with cf_delayed 0 is followed directly by cf_target.
- R5: A call (cf_op 2) redirects like a jump. A delayed call pushes its own address + 1 + SLOTS; an immediate call pushes its address + 1.
- R6: A return (cf_op 3) pops the most recent pushed address and redirects there. A delayed return first issues its own SLOTS slot instructions.
- R7: An interrupt request is held while slot instructions are still to come. It is taken in the cycle of the last slot or in any later cycle that opens no new window. When it is taken, irq_take is 1, the next fetch is IRQ_VEC, and irq_ret_addr holds the address that would otherwise have been fetched.
- R8: A request issued in a slot is ignored and fetch continues in sequence. slot_err becomes 1 and stays 1 until reset.
- R9: The return stack holds RAS_DEPTH entries. A push when full or a pop when empty sets the sticky ras_err and leaves the stack unchanged. A pop when empty causes no redirect, while a call when full still jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cf_op | input | 2 | Request of the instruction at fetch_addr: 0 none, 1 jump, 2 call, 3 return |
| cf_delayed | input | 1 | 1 selects delayed transfer |
| cf_target | input | AW | Jump or call target |
| irq_req | input | 1 | Interrupt request |
| fetch_addr | output | AW | Address of the instruction issued this cycle |
| fetch_valid | output | 1 | Fetch address is valid |
| irq_take | output | 1 | Interrupt taken this cycle |
| irq_ret_addr | output | AW | Interrupt return point |
| slot_err | output | 1 | Sticky: request seen inside a slot window |
| ras_err | output | 1 | Sticky: return stack overflow or underflow |

## Verification
The hardest situation to reach is an interrupt that arrives inside a slot window and must wait for the last slot. In that case the recorded return point is the pending target, not a sequential address. The stimulus raises the request on the delayed jump itself, so that it is latched before the first slot. It then checks that no take occurs on the first slot, that a take occurs on the last slot, and the return point. Overflow is reached by nesting one call more than the stack depth and then unwinding every return in LIFO order.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  typedef enum logic [1:0] {
    CF_NONE = 2'd0,
    CF_JUMP = 2'd1,
    CF_CALL = 2'd2,
    CF_RET  = 2'd3
  } cf_op_e;
endpackage

// File: rtl/dslot_slot_ctr.sv
module dslot_slot_ctr #(
  parameter int AW    = 16,
  parameter int SLOTS = 2,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          load,
  input  logic [AW-1:0] load_tgt,
  output logic          busy,
  output logic          last,
  output logic [AW-1:0] tgt
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tgt   <= '0;
    end else if (adv) begin
      if (load) begin
        cnt_q <= CW'(SLOTS);
        tgt   <= load_tgt;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1));

  // R3: a new window may only open once the previous one is over
  assert_reload_idle_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
  // R3: the counter never exceeds the slot count
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(SLOTS));
endmodule

// File: rtl/dslot_ret_stack.sv
module dslot_ret_stack #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          empty,
  output logic          err
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic          full;

  assign full     = (ptr_q == PW'(DEPTH));
  assign empty    = (ptr_q == '0);
  assign top_data = mem[IW'(ptr_q - 1'b1)];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      err   <= 1'b0;
    end else begin
      if (push) begin
        if (full) err <= 1'b1;
        else begin
          mem[IW'(ptr_q)] <= push_data;
          ptr_q           <= ptr_q + 1'b1;
        end
      end else if (pop) begin
        if (empty) err <= 1'b1;
        else       ptr_q <= ptr_q - 1'b1;
      end
    end
  end

  assert_ptr_bound_R9: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PW'(DEPTH));
  assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (ptr_q == $past(ptr_q)) && err);
  assert_empty_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> (ptr_q == $past(ptr_q)) && err);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/dslot_irq_gate.sv
module dslot_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic irq_req,
  input  logic allow,
  output logic take
);
  logic pend_q;

  assign take = allow && (pend_q || irq_req);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q || irq_req) && !take;
  end

  // R7: a held request is never lost while it waits
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !take) |=> pend_q);
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
  import dslot_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          SLOTS     = 2,
  parameter int          RAS_DEPTH = 8,
  parameter logic [15:0] IRQ_VEC   = 16'h0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cf_op,
  input  logic          cf_delayed,
  input  logic [AW-1:0] cf_target,
  input  logic          irq_req,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_valid,
  output logic          irq_take,
  output logic [AW-1:0] irq_ret_addr,
  output logic          slot_err,
  output logic          ras_err
);
  localparam logic [AW-1:0] VEC = AW'(IRQ_VEC);

  function automatic logic [AW-1:0] push_point(input logic [AW-1:0] pc,
                                               input logic dly);
    return pc + AW'(1) + (dly ? AW'(SLOTS) : AW'(0));
  endfunction

  logic [AW-1:0] pc_q, nrm_next, dest, ras_top, slot_tgt;
  logic          valid_q, in_slot, slot_last, ras_empty;
  logic          cf_req, illegal, legal, xfer, start_delay, push, pop, allow;
  cf_op_e        op;

  assign op          = cf_op_e'(cf_op);
  assign cf_req      = valid_q && (op != CF_NONE);
  assign illegal     = cf_req && in_slot;
  assign legal       = cf_req && !in_slot;
  assign push        = legal && (op == CF_CALL);
  assign pop         = legal && (op == CF_RET);
  assign xfer        = legal && ((op != CF_RET) || !ras_empty);
  assign dest        = (op == CF_RET) ? ras_top : cf_target;
  assign start_delay = xfer && cf_delayed;
  assign allow       = valid_q && !start_delay && (!in_slot || slot_last);

  always_comb begin
    if (!valid_q)                   nrm_next = pc_q;
    else if (in_slot && slot_last)  nrm_next = slot_tgt;
    else if (xfer && !cf_delayed)   nrm_next = dest;
    else                            nrm_next = pc_q + AW'(1);
  end

  dslot_slot_ctr #(.AW(AW), .SLOTS(SLOTS)) u_slot (
    .clk(clk), .rst(rst), .adv(valid_q), .load(start_delay),
    .load_tgt(dest), .busy(in_slot), .last(slot_last), .tgt(slot_tgt));

  dslot_ret_stack #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_data(push_point(pc_q, cf_delayed)), .top_data(ras_top),
    .empty(ras_empty), .err(ras_err));

  dslot_irq_gate u_irq (
    .clk(clk), .rst(rst), .irq_req(irq_req), .allow(allow), .take(irq_take));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= '0;
      valid_q      <= 1'b0;
      slot_err     <= 1'b0;
      irq_ret_addr <= '0;
    end else begin
      valid_q <= 1'b1;
      pc_q    <= irq_take ? VEC : nrm_next;
      if (irq_take) irq_ret_addr <= nrm_next;
      if (illegal)  slot_err     <= 1'b1;
    end
  end

  assign fetch_addr  = pc_q;
  assign fetch_valid = valid_q;

  assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !in_slot && cf_op == 2'd0 && !irq_take)
      |=> fetch_addr == $past(fetch_addr) + AW'(1));
  assert_slot_seq_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && in_slot && !slot_last) |=> fetch_addr == $past(fetch_addr) + AW'(1));
  assert_slot_exit_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && slot_last && !irq_take) |=> fetch_addr == $past(slot_tgt));
  assert_jump_now_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !in_slot && cf_op == 2'd1 && !cf_delayed && !irq_take)
      |=> fetch_addr == $past(cf_target));
  assert_slot_irq_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (in_slot && !slot_last) |-> !irq_take);
  assert_irq_vector_R7: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> fetch_addr == VEC);
  assert_illegal_flag_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |=> slot_err);
  assert_slot_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    slot_err |=> slot_err);
endmodule

// File: tb/dslot_pc_seq_tb.sv
module dslot_pc_seq_tb;
  localparam int AW = 16;
  localparam int NV = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cf_op = 2'd0;
  logic          cf_delayed = 1'b0;
  logic [AW-1:0] cf_target = '0;
  logic          irq_req = 1'b0;
  logic [AW-1:0] fetch_addr, irq_ret_addr;
  logic          fetch_valid, irq_take, slot_err, ras_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dslot_pc_seq u_dut (
    .clk(clk), .rst(rst), .cf_op(cf_op), .cf_delayed(cf_delayed),
    .cf_target(cf_target), .irq_req(irq_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .irq_take(irq_take),
    .irq_ret_addr(irq_ret_addr), .slot_err(slot_err), .ras_err(ras_err));

  // row: req tag, op, delayed, target, irq, expected fetch, expected take
  function automatic logic [40:0] mk(input int rq, input logic [1:0] op,
      input logic d, input logic [15:0] t, input logic i,
      input logic [15:0] e, input logic tk);
    return {4'(rq), op, d, t, i, e, tk};
  endfunction

  localparam logic [40:0] VEC [NV] = '{
    mk(1, 0, 0, 16'h0000, 0, 16'h0000, 0),  // R1 first valid fetch
    mk(2, 0, 0, 16'h0000, 0, 16'h0001, 0),  // R2
    mk(2, 1, 1, 16'h0020, 0, 16'h0002, 0),  // R3 delayed jump
    mk(3, 0, 0, 16'h0000, 0, 16'h0003, 0),
    mk(3, 0, 0, 16'h0000, 0, 16'h0004, 0),
    mk(3, 2, 1, 16'h0040, 0, 16'h0020, 0),  // R5 delayed call pushes 0x23
    mk(5, 0, 0, 16'h0000, 0, 16'h0021, 0),
    mk(5, 0, 0, 16'h0000, 0, 16'h0022, 0),
    mk(5, 0, 0, 16'h0000, 0, 16'h0040, 0),
    mk(6, 3, 1, 16'h0000, 0, 16'h0041, 0),  // R6 delayed return
    mk(6, 0, 0, 16'h0000, 0, 16'h0042, 0),
    mk(6, 0, 0, 16'h0000, 0, 16'h0043, 0),
    mk(6, 1, 0, 16'h0060, 0, 16'h0023, 0),  // R4 immediate jump
    mk(4, 2, 0, 16'h0080, 0, 16'h0060, 0),  // R5 immediate call pushes 0x61
    mk(5, 3, 0, 16'h0000, 0, 16'h0080, 0),  // R6 immediate return
    mk(6, 1, 1, 16'h0090, 1, 16'h0061, 0),  // R7 irq on delayed jump
    mk(7, 0, 0, 16'h0000, 0, 16'h0062, 0),  // held in first slot
    mk(7, 0, 0, 16'h0000, 0, 16'h0063, 1),  // taken on last slot
    mk(7, 0, 0, 16'h0000, 0, 16'h0100, 0),
    mk(7, 1, 1, 16'h00A0, 0, 16'h0101, 0),
    mk(8, 1, 0, 16'h0300, 0, 16'h0102, 0),  // R8 jump inside slot
    mk(8, 0, 0, 16'h0000, 0, 16'h0103, 0),
    mk(8, 0, 0, 16'h0000, 0, 16'h00A0, 0),
    mk(3, 0, 0, 16'h0000, 0, 16'h00A1, 0)
  };

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic d,
                       input logic [15:0] t, input logic i);
    cf_op = op; cf_delayed = d; cf_target = t; irq_req = i;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    drive(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    check("R1 valid", 32'(fetch_valid), 0);
    check("R1 addr", 32'(fetch_addr), 0);
    check("R1 flags", {30'd0, slot_err, ras_err}, 0);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] pc;
    do_reset();
    for (int k = 0; k < NV; k++) begin
      logic [40:0] v;
      v = VEC[k];
      @(negedge clk);
      check($sformatf("R%0d row %0d addr", v[40:37], k), 32'(fetch_addr), 32'(v[16:1]));
      drive(v[36:35], v[34], v[33:18], v[17]);
      #1;
      check($sformatf("R%0d row %0d take", v[40:37], k), 32'(irq_take), 32'(v[0]));
    end
    @(negedge clk);
    check("R7 irq return point", 32'(irq_ret_addr), 32'h90);
    check("R8 slot_err sticky", 32'(slot_err), 1);
    check("R9 no stack error", 32'(ras_err), 0);

    // R7: interrupt outside a window, return point is the next sequential address
    do_reset();
    @(negedge clk); drive(0, 0, 0, 0);
    @(negedge clk); drive(0, 0, 0, 1);
    check("R2 addr before irq", 32'(fetch_addr), 1);
    #1; check("R7 immediate take", 32'(irq_take), 1);
    @(negedge clk); drive(0, 0, 0, 0);
    check("R7 vector", 32'(fetch_addr), 32'h100);
    check("R7 ret point", 32'(irq_ret_addr), 2);

    // R9: return on empty stack
    do_reset();
    @(negedge clk); drive(3, 0, 0, 0);
    @(negedge clk); drive(0, 0, 0, 0);
    check("R9 underflow no redirect", 32'(fetch_addr), 1);
    check("R9 underflow flag", 32'(ras_err), 1);

    // R9: nest one call past the depth, then unwind
    do_reset();
    @(negedge clk);
    pc = 16'h0;
    for (int n = 0; n < 9; n++) begin
      check($sformatf("R5 call %0d addr", n), 32'(fetch_addr), 32'(pc));
      if (n == 8) check("R9 no flag at depth", 32'(ras_err), 0);
      drive(2, 0, pc + 16'h10, 0);
      pc = pc + 16'h10;
      @(negedge clk);
    end
    check("R9 overflow flag", 32'(ras_err), 1);
    check("R9 full call still jumps", 32'(fetch_addr), 32'h90);
    for (int n = 7; n >= 0; n--) begin
      drive(3, 0, 0, 0);
      @(negedge clk);
      check($sformatf("R6 lifo pop %0d", n), 32'(fetch_addr), 32'(n * 16 + 1));
    end
    drive(3, 0, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0);
    check("R9 empty after unwind", 32'(fetch_addr), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule